// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This is a purely combinational arithmetic and logic unit for a small 8-bit RISC core. In one evaluation it takes an operation code, two byte operands, the current status byte and a 3-bit bit index. It returns a result byte, the next status byte and a write-enable. The write-enable tells the register file whether to store the result.

Every operation touches only the flags it owns. All other status bits pass through from the input unchanged. The unit covers byte add and subtract with and without carry, compares, bitwise logic, complement, negate, increment and decrement. It also covers the left and right shifts, rotates through carry, nibble swap, setting or clearing one status bit, and moving the T bit to or from a register bit. The caller supplies immediates as the second operand. Bit-set and bit-clear on a register use OR and AND with a mask.

Top module: `alu8_flags`

## Requirements
- R1: The status byte holds, from bit 7 down to bit 0: I, T, H, S, V, N, Z, C. Operation codes 23 to 31 leave the status byte unchanged and hold `wr_en` low. `result` is only meaningful while `wr_en` is high.
- R2: Add (code 0) and add-with-carry (code 1) output a+b, or a+b+C for code 1, with `wr_en` high. C is the carry out of bit 7. H is the carry out of bit 3. V flags signed overflow. N and Z follow the result.
- R3: Subtract (code 2), subtract-with-carry (code 3) and negate (code 10) output a-b, a-b-C and 0-a respectively, with `wr_en` high. C is the borrow out of bit 7. H is the borrow into bit 4. V flags signed overflow. N and Z follow the result.
- R4: For subtract-with-carry (code 3) and compare-with-carry (code 5), Z is set only if the result is zero and Z was already set on input.
- R5: Compare (code 4) and compare-with-carry (code 5) set flags exactly as subtract and subtract-with-carry do, and hold `wr_en` low.
- R6: AND (code 6), OR (code 7) and XOR (code 8) output the bitwise result. They force V to 0, update N and Z, and keep C and H.
- R7: One's complement (code 9) outputs 0xFF minus a. It forces C to 1 and V to 0, updates N and Z, and keeps H.
- R8: Increment (code 11) and decrement (code 12) output a+1 and a-1. V is set only when the operand is 0x7F for increment, or 0x80 for decrement. C and H are kept.
- R9: Right shifts put a[0] into C. Logical shift right (code 14) shifts in 0 at bit 7. Rotate right (code 16) shifts the input C into bit 7. Arithmetic shift right (code 17) keeps bit 7. V is N XOR the new C. H is kept.
- R10: Left shifts put a[7] into C. Logical shift left (code 13) shifts in 0 at bit 0. Rotate left (code 15) shifts the input C into bit 0. V is N XOR the new C. H is kept.
- R11: Nibble swap (code 18) outputs {a[3:0], a[7:4]} and changes no flag.
- R12: Flag set (code 19) and flag clear (code 20) set or clear the status bit selected by `idx`, leave the other bits unchanged, and hold `wr_en` low.
- R13: T store (code 21) copies a[idx] into T with `wr_en` low. T load (code 22) outputs a with bit idx replaced by T, with `wr_en` high and no flag change.
- R14: On every operation that updates N or V, S equals N XOR V. The I bit changes only under codes 19 and 20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 5 | Operation code |
| a | input | 8 | First operand, also the destination value |
| b | input | 8 | Second operand or immediate |
| sreg_in | input | 8 | Current status byte |
| idx | input | 3 | Bit index for flag and T-bit operations |
| result | output | 8 | Result byte |
| sreg_out | output | 8 | Next status byte |
| wr_en | output | 1 | Result is to be written back |

## Verification
Directed operands sit at the flag boundaries. Pairs of 0x0F+0x01 and 0x7F+0x01 separate the half-carry from the signed overflow. Operands 0xFF+0x01 and 0x80 under negate separate the carry from the zero flag. A zero difference is tried with Z both low and high on input, so a plain zero test can be told apart from the chained one. Shifts and rotates use operands with both end bits set, so the incoming-carry path is distinct from the shifted-in zero. Random operands with random status bytes then run across all 32 codes, unused ones included, which exposes any operation that disturbs a flag outside its own set.

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic [4:0] op,
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic [7:0] sreg_in,
  input  logic [2:0] idx,
  output logic [7:0] result,
  output logic [7:0] sreg_out,
  output logic       wr_en
);
  localparam logic [4:0] OP_ADD  = 5'd0;
  localparam logic [4:0] OP_ADC  = 5'd1;
  localparam logic [4:0] OP_SUB  = 5'd2;
  localparam logic [4:0] OP_SBC  = 5'd3;
  localparam logic [4:0] OP_CP   = 5'd4;
  localparam logic [4:0] OP_CPC  = 5'd5;
  localparam logic [4:0] OP_AND  = 5'd6;
  localparam logic [4:0] OP_OR   = 5'd7;
  localparam logic [4:0] OP_XOR  = 5'd8;
  localparam logic [4:0] OP_COM  = 5'd9;
  localparam logic [4:0] OP_NEG  = 5'd10;
  localparam logic [4:0] OP_INC  = 5'd11;
  localparam logic [4:0] OP_DEC  = 5'd12;
  localparam logic [4:0] OP_LSL  = 5'd13;
  localparam logic [4:0] OP_LSR  = 5'd14;
  localparam logic [4:0] OP_ROL  = 5'd15;
  localparam logic [4:0] OP_ROR  = 5'd16;
  localparam logic [4:0] OP_ASR  = 5'd17;
  localparam logic [4:0] OP_SWAP = 5'd18;
  localparam logic [4:0] OP_FSET = 5'd19;
  localparam logic [4:0] OP_FCLR = 5'd20;
  localparam logic [4:0] OP_TST  = 5'd21;
  localparam logic [4:0] OP_TLD  = 5'd22;

  localparam int FI = 7, FT = 6, FH = 5, FS = 4, FV = 3, FN = 2, FZ = 1, FC = 0;

  logic       cin, use_c, z_chain;
  logic [8:0] add_w, sub_w;
  logic [7:0] sub_x, sub_y, add_r, sub_r, inc_r, dec_r;
  logic       h_add, v_add, h_sub, v_sub, c_sub;

  assign cin     = sreg_in[FC];
  assign use_c   = (op == OP_ADC) || (op == OP_SBC) || (op == OP_CPC);
  assign z_chain = (op == OP_SBC) || (op == OP_CPC);

  assign add_w = {1'b0, a} + {1'b0, b} + {8'd0, use_c & cin};
  assign add_r = add_w[7:0];
  assign h_add = (a[3] & b[3]) | (b[3] & ~add_r[3]) | (~add_r[3] & a[3]);
  assign v_add = (a[7] & b[7] & ~add_r[7]) | (~a[7] & ~b[7] & add_r[7]);

  assign sub_x = (op == OP_NEG) ? 8'h00 : a;
  assign sub_y = (op == OP_NEG) ? a : b;
  assign sub_w = {1'b0, sub_x} - {1'b0, sub_y} - {8'd0, use_c & cin};
  assign sub_r = sub_w[7:0];
  assign h_sub = (~sub_x[3] & sub_y[3]) | (sub_y[3] & sub_r[3]) | (sub_r[3] & ~sub_x[3]);
  assign v_sub = (sub_x[7] & ~sub_y[7] & ~sub_r[7]) | (~sub_x[7] & sub_y[7] & sub_r[7]);
  assign c_sub = (~sub_x[7] & sub_y[7]) | (sub_y[7] & sub_r[7]) | (sub_r[7] & ~sub_x[7]);

  assign inc_r = a + 8'd1;
  assign dec_r = a - 8'd1;

  logic [7:0] res, flg;
  logic       we, upd;

  always_comb begin
    res = a;
    flg = sreg_in;
    we  = 1'b0;
    upd = 1'b0;
    case (op)
      OP_ADD, OP_ADC: begin
        res = add_r; we = 1'b1; upd = 1'b1;
        flg[FC] = add_w[8]; flg[FH] = h_add; flg[FV] = v_add;
      end
      OP_SUB, OP_SBC, OP_NEG, OP_CP, OP_CPC: begin
        res = sub_r; upd = 1'b1;
        we  = (op != OP_CP) && (op != OP_CPC);
        flg[FC] = c_sub; flg[FH] = h_sub; flg[FV] = v_sub;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res = (op == OP_AND) ? (a & b) : (op == OP_OR) ? (a | b) : (a ^ b);
        we = 1'b1; upd = 1'b1; flg[FV] = 1'b0;
      end
      OP_COM: begin
        res = ~a; we = 1'b1; upd = 1'b1;
        flg[FC] = 1'b1; flg[FV] = 1'b0;
      end
      OP_INC: begin
        res = inc_r; we = 1'b1; upd = 1'b1;
        flg[FV] = ~a[7] & inc_r[7];
      end
      OP_DEC: begin
        res = dec_r; we = 1'b1; upd = 1'b1;
        flg[FV] = a[7] & ~dec_r[7];
      end
      OP_LSL, OP_ROL: begin
        res = {a[6:0], (op == OP_ROL) & cin};
        we = 1'b1; upd = 1'b1;
        flg[FC] = a[7];
        flg[FV] = res[7] ^ a[7];
      end
      OP_LSR, OP_ROR, OP_ASR: begin
        res = {(op == OP_ROR) ? cin : (op == OP_ASR) & a[7], a[7:1]};
        we = 1'b1; upd = 1'b1;
        flg[FC] = a[0];
        flg[FV] = res[7] ^ a[0];
      end
      OP_SWAP: begin
        res = {a[3:0], a[7:4]}; we = 1'b1;
      end
      OP_FSET: flg[idx] = 1'b1;
      OP_FCLR: flg[idx] = 1'b0;
      OP_TST:  flg[FT] = a[idx];
      OP_TLD: begin
        res = a; res[idx] = sreg_in[FT]; we = 1'b1;
      end
      default: ;
    endcase
    if (upd) begin
      flg[FN] = res[7];
      flg[FZ] = (res == 8'h00) & (~z_chain | sreg_in[FZ]);
      flg[FS] = flg[FN] ^ flg[FV];
    end
  end

  assign result   = res;
  assign sreg_out = flg;
  assign wr_en    = we;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
  input logic [4:0] op,
  input logic [7:0] sreg_in,
  input logic [7:0] sreg_out,
  input logic       wr_en
);
  logic known;
  assign known = !$isunknown({op, sreg_in});

  always_comb begin
    if (known) begin
      if (op == 5'd4 || op == 5'd5)
        p_compare_nowrite_r5: assert (!wr_en) else $error("compare wrote back");
      if ((op == 5'd3 || op == 5'd5) && !sreg_in[1])
        p_zero_chain_r4: assert (!sreg_out[1]) else $error("Z set without prior Z");
      if (op == 5'd6 || op == 5'd7 || op == 5'd8)
        p_logic_keeps_carry_r6: assert (sreg_out[0] == sreg_in[0] && sreg_out[5] == sreg_in[5] && !sreg_out[3])
          else $error("logic op flag violation");
      if (op == 5'd18 || op >= 5'd23)
        p_no_flag_change_r11: assert (sreg_out == sreg_in) else $error("flags changed");
      if (op >= 5'd23)
        p_idle_nowrite_r1: assert (!wr_en) else $error("unused code wrote back");
      if (op <= 5'd17)
        p_sign_is_nxv_r14: assert (sreg_out[4] == (sreg_out[2] ^ sreg_out[3])) else $error("S != N^V");
      if (op != 5'd19 && op != 5'd20)
        p_i_flag_kept_r14: assert (sreg_out[7] == sreg_in[7]) else $error("I changed");
      if (op == 5'd9)
        p_com_carry_r7: assert (sreg_out[0] && !sreg_out[3]) else $error("complement flags");
    end
  end
endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .op(op), .sreg_in(sreg_in), .sreg_out(sreg_out), .wr_en(wr_en)
);

// File: tb/tb_alu8_flags.sv
module tb_alu8_flags;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [4:0] op = '0;
  logic [7:0] a = '0, b = '0, sreg_in = '0;
  logic [2:0] idx = '0;
  logic [7:0] result, sreg_out;
  logic       wr_en;

  int checks = 0, fails = 0;
  bit done = 0;

  alu8_flags dut (
    .op(op), .a(a), .b(b), .sreg_in(sreg_in), .idx(idx),
    .result(result), .sreg_out(sreg_out), .wr_en(wr_en)
  );

  function automatic logic [16:0] model(input int code, input logic [7:0] x, input logic [7:0] y,
                                        input logic [7:0] s, input int ix);
    logic [7:0] res, o;
    bit we, upd, zst;
    int r, c, sv, sx, sy;
    o = s; res = x; we = 0; upd = 0; zst = 0;
    sx = $signed(x); sy = $signed(y);
    case (code)
      0, 1: begin
        c = (code == 1) ? int'(s[0]) : 0;
        r = x + y + c; res = r[7:0];
        o[0] = r > 255; o[5] = ((x % 16) + (y % 16) + c) > 15;
        sv = sx + sy + c; o[3] = (sv > 127) || (sv < -128);
        upd = 1; we = 1;
      end
      2, 3, 4, 5, 10: begin
        logic [7:0] m, n;
        int sm, sn;
        m = (code == 10) ? 8'h00 : x; n = (code == 10) ? x : y;
        sm = $signed(m); sn = $signed(n);
        c = (code == 3 || code == 5) ? int'(s[0]) : 0;
        r = m - n - c; res = r[7:0];
        o[0] = int'(m) < int'(n) + c; o[5] = (m % 16) < (n % 16) + c;
        sv = sm - sn - c; o[3] = (sv > 127) || (sv < -128);
        upd = 1; we = !(code == 4 || code == 5); zst = (code == 3 || code == 5);
      end
      6: begin res = x & y; o[3] = 0; upd = 1; we = 1; end
      7: begin res = x | y; o[3] = 0; upd = 1; we = 1; end
      8: begin res = x ^ y; o[3] = 0; upd = 1; we = 1; end
      9: begin res = 8'hFF - x; o[0] = 1; o[3] = 0; upd = 1; we = 1; end
      11: begin res = x + 8'd1; o[3] = (x == 8'h7F); upd = 1; we = 1; end
      12: begin res = x - 8'd1; o[3] = (x == 8'h80); upd = 1; we = 1; end
      13, 15: begin
        res = {x[6:0], (code == 15) ? s[0] : 1'b0}; o[0] = x[7];
        o[3] = res[7] ^ o[0]; upd = 1; we = 1;
      end
      14, 16, 17: begin
        res = x >> 1;
        if (code == 16) res[7] = s[0];
        if (code == 17) res[7] = x[7];
        o[0] = x[0]; o[3] = res[7] ^ o[0]; upd = 1; we = 1;
      end
      18: begin res = {x[3:0], x[7:4]}; we = 1; end
      19: o[ix] = 1'b1;
      20: o[ix] = 1'b0;
      21: o[6] = x[ix];
      22: begin res = x; res[ix] = s[6]; we = 1; end
      default: ;
    endcase
    if (upd) begin
      o[2] = res[7];
      o[1] = (res == 0) && (!zst || s[1]);
      o[4] = o[2] ^ o[3];
    end
    return {we, res, o};
  endfunction

  function automatic string req_of(input int code);
    case (code)
      0, 1: return "R2";
      2, 3, 10: return "R3";
      4, 5: return "R5";
      6, 7, 8: return "R6";
      9: return "R7";
      11, 12: return "R8";
      13, 15: return "R10";
      14, 16, 17: return "R9";
      18: return "R11";
      19, 20: return "R12";
      21, 22: return "R13";
      default: return "R1";
    endcase
  endfunction

  task automatic run(input int code, input logic [7:0] x, input logic [7:0] y,
                     input logic [7:0] s, input int ix, input string tag);
    logic [16:0] e;
    bit bad;
    @(negedge clk);
    op = code[4:0]; a = x; b = y; sreg_in = s; idx = ix[2:0];
    #1;
    e = model(code, x, y, s, ix);
    checks++;
    bad = (wr_en !== e[16]) || (sreg_out !== e[7:0]) || (e[16] && result !== e[15:8]);
    if (bad) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h s=%h idx=%0d: got we=%b res=%h sreg=%h, expected we=%b res=%h sreg=%h",
               tag, code, x, y, s, ix, wr_en, result, sreg_out, e[16], e[15:8], e[7:0]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1729));
    repeat (2) @(posedge clk);
    run(25, 8'h12, 8'h34, 8'hA5, 0, "R1");
    run(0, 8'h0F, 8'h01, 8'h00, 0, "R2");
    run(0, 8'h7F, 8'h01, 8'h00, 0, "R2");
    run(1, 8'hFF, 8'h00, 8'h01, 0, "R2");
    run(2, 8'h10, 8'h01, 8'h00, 0, "R3");
    run(10, 8'h80, 8'h00, 8'h00, 0, "R3");
    run(10, 8'h00, 8'h00, 8'h01, 0, "R3");
    run(3, 8'h05, 8'h05, 8'h00, 0, "R4");
    run(3, 8'h05, 8'h05, 8'h02, 0, "R4");
    run(5, 8'h06, 8'h05, 8'h03, 0, "R4");
    run(4, 8'h40, 8'h41, 8'h00, 0, "R5");
    run(6, 8'hF0, 8'h0F, 8'h29, 0, "R6");
    run(9, 8'h00, 8'h00, 8'h00, 0, "R7");
    run(11, 8'h7F, 8'h00, 8'h21, 0, "R8");
    run(12, 8'h80, 8'h00, 8'h21, 0, "R8");
    run(14, 8'h81, 8'h00, 8'h00, 0, "R9");
    run(16, 8'h81, 8'h00, 8'h01, 0, "R9");
    run(17, 8'h81, 8'h00, 8'h00, 0, "R9");
    run(13, 8'h81, 8'h00, 8'h01, 0, "R10");
    run(15, 8'h81, 8'h00, 8'h01, 0, "R10");
    run(18, 8'h3C, 8'h00, 8'hFF, 0, "R11");
    run(19, 8'h00, 8'h00, 8'h00, 7, "R12");
    run(20, 8'h00, 8'h00, 8'hFF, 0, "R12");
    run(21, 8'h08, 8'h00, 8'h00, 3, "R13");
    run(22, 8'h00, 8'h00, 8'h40, 5, "R13");
    run(2, 8'h00, 8'h80, 8'h80, 0, "R14");
    for (int i = 0; i < 4000; i++) begin
      int code;
      code = int'($urandom_range(31, 0));
      run(code, 8'($urandom), 8'($urandom), 8'($urandom), int'($urandom_range(7, 0)), req_of(code));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule